// File: doc/BRIEF.md
# SPI Control Register Write Engine

This engine sits on the host side of a full-duplex SPI link to a MAC-PHY and carries out one burst of consecutive control-register writes per request. A request gives a 20-bit start address and a register count. The engine first checks the count. It then builds a parity-protected 32-bit control header, lowers chip select and shifts out the header, one 32-bit value per register and one trailing filler word. Each word goes out most significant bit first. The write values are pulled from the requester one at a time through a ready/valid handshake, just before each word is shifted.

The far side returns everything it received, one word late. The engine drops the first returned word. It compares every later returned word with the word it sent one slot earlier. When the transaction ends, it pulses done if every compare matched, and a protocol error otherwise. A count of zero, or a count above 128, gets a parameter error pulse and starts no SPI activity. While a transaction runs, busy is high and further requests are ignored. The serial clock runs in mode 0: it idles low, MOSI moves after falling edges, and MISO is sampled on rising edges. Each half period of the serial clock lasts `clk_div + 1` system clocks.

The controller states are:
- `ST_IDLE`: waits for a request.
- `ST_REJECT`: one cycle that reports a bad count, then returns to `ST_IDLE`.
- `ST_HDR`: shifts the header. When the word completes, it goes to `ST_FETCH`.
- `ST_FETCH`: waits for a value from the requester, then goes to `ST_DATA`.
- `ST_DATA`: shifts a value. When the word completes, it goes back to `ST_FETCH` if values remain, or to `ST_TAIL` after the last one.
- `ST_TAIL`: shifts the filler word. When it completes, it goes to `ST_FINISH`.
- `ST_FINISH`: one cycle with chip select high that reports the result, then returns to `ST_IDLE`.

Top module: `ctlwr_engine`

## Requirements
- R1: The header's bit 31 is 0 (control), bit 30 is 0, bit 29 is 1 (write) and bit 28 is 0. Bits 27:24 carry `req_addr[19:16]`, and bits 23:8 carry `req_addr[15:0]`.
- R2: Header bits 7:1 carry the register count minus one, so a count of 128 gives 127. Bit 0 is set so that the 32-bit header has an odd number of ones.
- R3: Chip select stays low for one continuous span per accepted request. During that span the engine gives exactly 32·(count+2) serial clock rising edges. The words go out most significant bit first, in this order: the header, then the values in the order they were supplied, then an all-zero filler word.
- R4: A request with a count of 0, or a count above 128, pulses `err_param` for one cycle. Chip select is never lowered and `wdata_ready` is never raised for that request.
- R5: The first 32 bits received are ignored. Each later received word must equal the word sent in the previous slot. Any mismatch gives `err_proto` in place of `done`.
- R6: `busy` is high from the cycle after a request is taken until the result cycle ends. A `req_valid` while busy has no effect: it produces no result pulse and no change to the frame.
- R7: The engine takes each value with one `wdata_ready`/`wdata_valid` handshake, before that value's word is shifted. It makes exactly `count` handshakes, and it tolerates any stall by the requester.
- R8: `spi_sclk` is low whenever chip select is high, and `spi_mosi` changes only while `spi_sclk` is low. Two successive rising edges within a word are 2·(`clk_div`+1) system clocks apart.
- R9: Exactly one of `done`, `err_param` and `err_proto` pulses for one cycle per request, with chip select high. After reset, chip select is high, the serial clock is low and all of the outputs listed here are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| clk_div | input | DIV_W | Half period of the serial clock, minus one, in system clocks |
| req_valid | input | 1 | Request strobe (taken only in ST_IDLE) |
| req_addr | input | 20 | Start address: selector in bits 19:16, register address in bits 15:0 |
| req_count | input | CNT_W (9) | Number of registers to write |
| busy | output | 1 | A transaction or result cycle is in progress |
| wdata_ready | output | 1 | Engine wants the next write value |
| wdata_valid | input | 1 | Requester offers a write value |
| wdata | input | 32 | Write value |
| done | output | 1 | One-cycle pulse: transaction finished, echo matched |
| err_param | output | 1 | One-cycle pulse: count rejected |
| err_proto | output | 1 | One-cycle pulse: echo mismatch |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench targets the count boundaries 0, 1, 128 and 129:
- A design that gets the range check wrong either lowers chip select for a rejected count, or rejects a legal full burst.
- A wrong minus-one step in the length field shows up as a bad header for a count of 128.

The bench also corrupts single returned bits at chosen places:
- A flipped bit inside the first returned word must be ignored.
- A flipped bit in the header echo, or in the echo of the last value, must raise a protocol error.
- A design that compares the wrong slot either misses these errors or raises false ones.

Two further cases are covered:
- Random stalls on the value handshake, combined with random divider settings, expose a shifter that runs ahead of its data or keeps the wrong bit period.
- A request poked in mid-transfer exposes a design that does not ignore requests while busy.

// File: rtl/ctlwr_pkg.sv
package ctlwr_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 20;
    localparam int LEN_W    = 7;
    localparam int MAX_REGS = 1 << LEN_W;
    localparam int CNT_W    = LEN_W + 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_HDR,
        ST_FETCH,
        ST_DATA,
        ST_TAIL,
        ST_FINISH
    } ctl_state_t;
endpackage

// File: rtl/ctlwr_hdr.sv
module ctlwr_hdr
    import ctlwr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] hdr
);
    logic [LEN_W-1:0]  len_field;
    logic [WORD_W-2:0] body;

    // count of MAX_REGS wraps to all ones in the LEN_W-bit field
    assign len_field = count[LEN_W-1:0] - LEN_W'(1);
    assign body      = {1'b0, 1'b0, 1'b1, 1'b0, addr[19:16], addr[15:0], len_field};
    assign hdr       = {body, ~(^body)};
endmodule

// File: rtl/ctlwr_shift.sv
module ctlwr_shift
    import ctlwr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int BC_W = $clog2(WORD_W);
    localparam logic [BC_W-1:0] BIT_LAST = BC_W'(WORD_W - 1);

    logic              active;
    logic [BC_W-1:0]   bit_cnt;
    logic [DIV_W-1:0]  div_cnt;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            bit_cnt   <= '0;
            div_cnt   <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sclk      <= 1'b0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                tx_sh   <= tx_word;
                bit_cnt <= '0;
                div_cnt <= '0;
                sclk    <= 1'b0;
            end else if (active) begin
                if (div_cnt == div) begin
                    div_cnt <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[WORD_W-2:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_cnt == BIT_LAST) begin
                            active    <= 1'b0;
                            word_done <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sh   <= {tx_sh[WORD_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    assign mosi    = tx_sh[WORD_W-1];
    assign rx_word = rx_sh;
endmodule

// File: rtl/ctlwr_engine.sv
module ctlwr_engine
    import ctlwr_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    output logic              busy,
    output logic              wdata_ready,
    input  logic              wdata_valid,
    input  logic [WORD_W-1:0] wdata,
    output logic              done,
    output logic              err_param,
    output logic              err_proto,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    ctl_state_t        state, nxt;
    logic [CNT_W-1:0]  remaining;
    logic [WORD_W-1:0] cur_tx, last_tx;
    logic              mismatch;
    logic [WORD_W-1:0] hdr_word, ser_word, rx_word;
    logic              ser_start, ser_done, count_ok;

    assign count_ok = (req_count != '0) && (req_count <= CNT_W'(MAX_REGS));

    ctlwr_hdr u_hdr (
        .addr  (req_addr),
        .count (req_count),
        .hdr   (hdr_word)
    );

    ctlwr_shift #(.DIV_W(DIV_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (clk_div),
        .start     (ser_start),
        .tx_word   (ser_word),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .word_done (ser_done),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = count_ok ? ST_HDR : ST_REJECT;
            ST_REJECT: nxt = ST_IDLE;
            ST_HDR:    if (ser_done) nxt = ST_FETCH;
            ST_FETCH:  if (wdata_valid) nxt = ST_DATA;
            ST_DATA:   if (ser_done) nxt = (remaining == '0) ? ST_TAIL : ST_FETCH;
            ST_TAIL:   if (ser_done) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        spi_cs_n    = !((state == ST_HDR) || (state == ST_FETCH) ||
                        (state == ST_DATA) || (state == ST_TAIL));
        wdata_ready = (state == ST_FETCH);
        done        = (state == ST_FINISH) && !mismatch;
        err_proto   = (state == ST_FINISH) && mismatch;
        err_param   = (state == ST_REJECT);
        ser_start   = ((state == ST_IDLE) && req_valid && count_ok) ||
                      ((state == ST_FETCH) && wdata_valid) ||
                      ((state == ST_DATA) && ser_done && (remaining == '0));
        unique case (state)
            ST_IDLE:  ser_word = hdr_word;
            ST_FETCH: ser_word = wdata;
            default:  ser_word = '0;
        endcase
    end

    // datapath: value countdown, sent-word history, echo compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
            cur_tx    <= '0;
            last_tx   <= '0;
            mismatch  <= 1'b0;
        end else begin
            if ((state == ST_IDLE) && req_valid && count_ok) begin
                remaining <= req_count;
                mismatch  <= 1'b0;
            end else if ((state == ST_FETCH) && wdata_valid) begin
                remaining <= remaining - 1'b1;
            end
            if (ser_start) begin
                last_tx <= cur_tx;
                cur_tx  <= ser_word;
            end
            if (ser_done && ((state == ST_DATA) || (state == ST_TAIL)) &&
                (rx_word != last_tx)) begin
                mismatch <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctlwr_checker.sv
module ctlwr_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic wdata_ready,
    input logic done,
    input logic err_param,
    input logic err_proto,
    input logic spi_sclk,
    input logic spi_cs_n,
    input logic spi_mosi
);
    assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_mosi_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    assert_reject_nocs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_param |-> (spi_cs_n && !wdata_ready));

    assert_fetch_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_ready |-> (busy && !spi_cs_n));

    assert_take_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    assert_result_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_param, err_proto}));

    assert_result_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_proto) |-> spi_cs_n);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_proto) |=> !(done || err_proto));
endmodule

bind ctlwr_engine ctlwr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .wdata_ready (wdata_ready),
    .done        (done),
    .err_param   (err_param),
    .err_proto   (err_proto),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi)
);

// File: tb/ctlwr_engine_test.sv
`timescale 1ns/1ps
module ctlwr_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = 8'd0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic [8:0]  req_count = '0;
    logic        busy, wdata_ready, done, err_param, err_proto;
    logic        wdata_valid = 1'b0;
    logic [31:0] wdata = '0;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    ctlwr_engine uut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
        .req_valid(req_valid), .req_addr(req_addr), .req_count(req_count),
        .busy(busy), .wdata_ready(wdata_ready), .wdata_valid(wdata_valid), .wdata(wdata),
        .done(done), .err_param(err_param), .err_proto(err_proto),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // far-side model: echoes MOSI delayed by one word, optional bit flip
    logic [31:0] dly = '0;
    int  sbits = 0;
    int  cs_falls = 0;
    int  corrupt_idx = -1;
    int  t_edge0 = 0, t_edge1 = 0;
    logic [31:0] capw [0:135];

    assign spi_miso = dly[31] ^ ((corrupt_idx >= 0) && (sbits == corrupt_idx));

    always @(negedge spi_cs_n) begin
        cs_falls++;
        sbits = 0;
        dly   = '0;
    end

    always @(posedge spi_sclk) begin
        if (sbits == 0) t_edge0 = cyc;
        if (sbits == 1) t_edge1 = cyc;
        if (sbits < 136 * 32) capw[sbits / 32][31 - (sbits % 32)] = spi_mosi;
        dly = {dly[30:0], spi_mosi};
        sbits++;
    end

    // value supplier with random stalls
    logic [31:0] vals [0:127];
    int prov_idx = 0;
    always @(negedge clk) begin
        if (wdata_valid) begin
            wdata_valid = 1'b0;
            prov_idx++;
        end else if (wdata_ready && ($urandom_range(0, 2) == 0)) begin
            wdata       = vals[prov_idx];
            wdata_valid = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_hdr(input logic [19:0] a, input int n);
        logic [31:0] h;
        int ones;
        logic [6:0] l;
        l = 7'(n - 1);
        h = 32'h2000_0000 | (32'(a[19:16]) << 24) | (32'(a[15:0]) << 8) | (32'(l) << 1);
        ones = $countones(h);
        if (ones % 2 == 0) h[0] = 1'b1;
        return h;
    endfunction

    // kind: 0 done, 1 parameter error, 2 protocol error
    task automatic run_txn(input logic [19:0] a, input int n, input int d,
                           input int cidx, input bit poke, input int exp_kind);
        int kind = -1;
        bit saw_param = 0;
        int falls0;
        int eh;
        bit data_ok = 1;
        for (int i = 0; i < 136; i++) capw[i] = '0;
        falls0      = cs_falls;
        prov_idx    = 0;
        corrupt_idx = cidx;
        @(negedge clk);
        clk_div   = 8'(d);
        req_addr  = a;
        req_count = 9'(n);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int it = 0; it < 60000; it++) begin
            if (it > 0) @(negedge clk);
            if (poke && it == 30) begin req_valid = 1'b1; req_count = 9'd0; end
            if (poke && it == 31) req_valid = 1'b0;
            if (err_param && it > 0) saw_param = 1;
            if (done)      begin kind = 0; break; end
            if (err_param && it == 0) begin kind = 1; break; end
            if (err_proto) begin kind = 2; break; end
        end
        check(kind == exp_kind, exp_kind == 1 ? "R4 result" : (exp_kind == 2 ? "R5 result" : "R9 result"),
              64'(kind), 64'(exp_kind));
        check(spi_cs_n == 1'b1, "R9 cs high at result", 64'(spi_cs_n), 64'd1);
        @(negedge clk);
        check(!(done || err_param || err_proto), "R9 single pulse", 64'({done, err_param, err_proto}), 64'd0);
        if (exp_kind == 1) begin
            check(cs_falls == falls0, "R4 no cs", 64'(cs_falls - falls0), 64'd0);
            check(prov_idx == 0, "R4 no fetch", 64'(prov_idx), 64'd0);
        end else begin
            eh = int'(exp_hdr(a, n));
            check(capw[0] == 32'(eh), "R1 R2 header", 64'(capw[0]), 64'(32'(eh)));
            for (int i = 0; i < n; i++) if (capw[i + 1] != vals[i]) data_ok = 0;
            check(data_ok, "R3 data words", 64'(data_ok), 64'd1);
            check(capw[n + 1] == 32'd0, "R3 filler word", 64'(capw[n + 1]), 64'd0);
            check(sbits == 32 * (n + 2), "R3 edge count", 64'(sbits), 64'(32 * (n + 2)));
            check(cs_falls == falls0 + 1, "R3 one cs span", 64'(cs_falls - falls0), 64'd1);
            check(prov_idx == n, "R7 handshakes", 64'(prov_idx), 64'(n));
            check(t_edge1 - t_edge0 == 2 * (d + 1), "R8 bit period", 64'(t_edge1 - t_edge0), 64'(2 * (d + 1)));
            if (poke) check(!saw_param, "R6 request ignored while busy", 64'(saw_param), 64'd0);
        end
        corrupt_idx = -1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 128; i++) vals[i] = $urandom();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n && !spi_sclk && !busy && !wdata_ready && !done && !err_param && !err_proto,
              "R9 reset state", 64'({spi_cs_n, spi_sclk, busy, wdata_ready, done, err_param, err_proto}),
              64'h40);

        run_txn(20'h3_0104, 1, 1, -1, 0, 0);
        run_txn(20'hA_BCDE, 128, 0, -1, 0, 0);
        run_txn(20'h0_0010, 0, 0, -1, 0, 1);
        run_txn(20'h0_0010, 129, 0, -1, 0, 1);
        run_txn(20'h0_0010, 300, 0, -1, 0, 1);
        run_txn(20'h1_0020, 3, 1, 10, 0, 0);
        run_txn(20'h1_0020, 3, 1, 35, 0, 2);
        run_txn(20'h2_0F00, 4, 0, 32 * 5 + 31, 0, 2);
        run_txn(20'h5_5555, 2, 2, -1, 1, 0);

        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < 8; i++) vals[i] = $urandom();
            run_txn(20'($urandom()), int'($urandom_range(1, 8)), int'($urandom_range(0, 3)), -1, 0, 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule